// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block holds a set of byte-wide configuration registers. Each register has a staging (shadow) copy and an in-use (active) copy. Ordinary writes change only the staging copy. A write of a fixed trigger code to a dedicated commit address copies every staging byte into its active copy on the same clock edge. Software can therefore prepare a group of related settings, such as a set of filter coefficients, and have them all take effect together. The downstream logic never sees a half-updated group.

Per-register attributes are set by parameters. A register marked *immediate* also changes its active copy on the edge where its byte is written. A register marked *self-clearing* requests an action: its bits are set by software and committed like any other register. Each bit is cleared again when the consuming logic reports, through a per-bit done input, that the action has finished.

The block has a single byte port with one address. A write strobe applies to that address, and the read data is a combinational view of the staging copy at that address. All active copies are presented together on one wide bus. Multi-byte parameters occupy consecutive addresses, with the least significant byte at the lowest address.

Top module: `shadow_cfg_bank`

## Requirements
- R1: After reset, every staging and active copy holds its parameter default value (defaults 0x00, 0x11, 0x22, 0x00, 0x44, 0x55, 0x66, 0x77 for registers 0 to 7), and a read of the commit address returns 0x00.
- R2: A write to a mapped, non-immediate register changes the value read back at that address from the next cycle on, and leaves the active bus unchanged.
- R3: A write of 0x01 to the commit address 0x005 copies every staging byte into its active copy on that clock edge, visible on the active bus in the following cycle.
- R4: A write of any other value to 0x005 changes nothing, and a read of 0x005 always returns 0x00.
- R5: A write to an immediate register (register 2 by default) puts the written byte on its active lane in the following cycle, without a commit.
- R6: For a self-clearing register (register 3 by default), a done bit set to 1 clears that bit in both copies on the next edge. Done bits aimed at any other register have no effect.
- R7: When a write to a self-clearing register coincides with done bits for it, the written byte lands in the staging copy unchanged.
- R8: Addresses outside the mapped registers (registers at 0x010 to 0x017) and outside 0x005 read as 0x00, and writes to them change no register.
- R9: Register i (address 0x010+i) drives bits 8i+7 down to 8i of the active bus, so a multi-byte parameter placed at ascending addresses appears least significant byte first.
- R10: When a commit coincides with done bits on a self-clearing register, the committed active value has those bits already cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 12 | Byte address for write and read |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Staging copy at `addr`, zero if unmapped |
| done_i | input | 64 | Per-bit action-finished flags, lane i for register i |
| active_o | output | 64 | Active copies of all registers, lane i for register i |

## Verification
The assertions assume that the commit address lies outside the mapped register window, so a single write never both commits and targets a register. They also assume that done bits for a register are only meaningful on lanes flagged self-clearing. The stimulus keeps the commit address fixed at 0x005, away from the window at 0x010. It drives done bits on every lane, so the no-effect case on ordinary registers is exercised rather than avoided. Random cycles mix window writes, commit writes with right and wrong codes, unmapped writes and idle cycles, with done pulses in a quarter of them.

// File: rtl/scb_pkg.sv
package scb_pkg;
    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t shadow;
        byte_t active;
    } cell_t;
endpackage

// File: rtl/scb_decode.sv
module scb_decode #(
    parameter int                 ADDR_W   = 12,
    parameter int                 NREG     = 8,
    parameter logic [ADDR_W-1:0]  REG_BASE = 12'h010,
    parameter logic [ADDR_W-1:0]  UPD_ADDR = 12'h005,
    parameter logic [7:0]         UPD_CODE = 8'h01,
    localparam int                IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [NREG-1:0]   wr_hit,
    output logic              upd_fire,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx
);
    logic [ADDR_W-1:0] off;
    logic              in_win;

    always_comb begin
        off      = addr - REG_BASE;
        in_win   = (addr >= REG_BASE) && (off < ADDR_W'(NREG));
        rd_valid = in_win;
        rd_idx   = off[IDX_W-1:0];
        upd_fire = wr_en && (addr == UPD_ADDR) && (wr_data == UPD_CODE);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign wr_hit[i] = wr_en && in_win && (off == ADDR_W'(i));
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit)); // R8
    AST_COMMIT_NOT_REG: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |-> (wr_hit == '0)); // R4
endmodule

// File: rtl/scb_cell.sv
module scb_cell
    import scb_pkg::*;
#(
    parameter logic  LIVE = 1'b0,
    parameter logic  ACLR = 1'b0,
    parameter byte_t RST  = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  byte_t wr_data,
    input  logic  upd,
    input  byte_t done,
    output byte_t shadow_o,
    output byte_t active_o
);
    cell_t q, d;
    byte_t clr;

    always_comb begin
        clr = ACLR ? done : 8'h00;
        d   = q;
        if (wr_hit) d.shadow = wr_data;
        else        d.shadow = q.shadow & ~clr;
        if (LIVE && wr_hit) d.active = wr_data;
        else if (upd)       d.active = q.shadow & ~clr;
        else                d.active = q.active & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{shadow: RST, active: RST};
        else        q <= d;
    end

    assign shadow_o = q.shadow;
    assign active_o = q.active;

    if (!ACLR) begin : g_plain
        AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            upd |=> active_o == $past(shadow_o)); // R3
        if (!LIVE) begin : g_held
            AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !upd |=> $stable(active_o)); // R2
        end
    end
    if (LIVE) begin : g_live
        AST_LIVE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit |=> active_o == $past(wr_data)); // R5
    end
    if (ACLR) begin : g_aclr
        AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit |=> shadow_o == $past(wr_data)); // R7
        AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit |=> (shadow_o & $past(done)) == 8'h00); // R6
        AST_ACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !(LIVE && wr_hit) |=> (active_o & $past(done)) == 8'h00); // R10
    end
endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
    import scb_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter int                 NREG      = 8,
    parameter logic [ADDR_W-1:0]  REG_BASE  = 12'h010,
    parameter logic [ADDR_W-1:0]  UPD_ADDR  = 12'h005,
    parameter logic [7:0]         UPD_CODE  = 8'h01,
    parameter logic [NREG-1:0]    LIVE_MASK = 8'h04,
    parameter logic [NREG-1:0]    ACLR_MASK = 8'h08,
    parameter logic [NREG*8-1:0]  RST_VALS  = 64'h7766_5544_0022_1100,
    localparam int                IDX_W     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic [NREG*8-1:0]  done_i,
    output logic [NREG*8-1:0]  active_o
);
    logic [NREG-1:0] wr_hit;
    logic            upd_fire;
    logic            rd_valid;
    logic [IDX_W-1:0] rd_idx;
    byte_t           shadow_w [NREG];

    scb_decode #(
        .ADDR_W  (ADDR_W),
        .NREG    (NREG),
        .REG_BASE(REG_BASE),
        .UPD_ADDR(UPD_ADDR),
        .UPD_CODE(UPD_CODE)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_hit  (wr_hit),
        .upd_fire(upd_fire),
        .rd_valid(rd_valid),
        .rd_idx  (rd_idx)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        scb_cell #(
            .LIVE(LIVE_MASK[i]),
            .ACLR(ACLR_MASK[i]),
            .RST (RST_VALS[8*i +: 8])
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[i]),
            .wr_data (wr_data),
            .upd     (upd_fire),
            .done    (done_i[8*i +: 8]),
            .shadow_o(shadow_w[i]),
            .active_o(active_o[8*i +: 8])
        );
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_valid) rd_data = shadow_w[rd_idx];
    end

    AST_UPD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == UPD_ADDR) |-> (rd_data == 8'h00)); // R4
    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && done_i == '0) |=> $stable(active_o)); // R8
endmodule

// File: tb/shadow_cfg_bank_tb.sv
`timescale 1ns/1ps
module shadow_cfg_bank_tb;
    localparam int NREG = 8;
    localparam logic [63:0] RSTV = 64'h7766_5544_0022_1100;
    localparam logic [7:0]  LIVEM = 8'h04;
    localparam logic [7:0]  ACLRM = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [63:0] done_i = '0;
    logic [63:0] active_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_sh [NREG];
    logic [7:0] m_ac [NREG];

    always #2.5 clk = ~clk;

    shadow_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .done_i(done_i),
        .active_o(active_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_bus();
        logic [63:0] v;
        for (int i = 0; i < NREG; i++) v[8*i +: 8] = m_ac[i];
        return v;
    endfunction

    function automatic logic [7:0] model_read(input logic [11:0] a);
        if (a >= 12'h010 && a < 12'h018) return m_sh[a - 12'h010];
        return 8'h00;
    endfunction

    // Advance the model by one edge using the requirement rules R2 to R10.
    task automatic model_step(input logic we, input logic [11:0] a,
                              input logic [7:0] d, input logic [63:0] dn);
        logic upd;
        logic [7:0] clr, nsh [NREG], nac [NREG];
        upd = we && a == 12'h005 && d == 8'h01;
        for (int i = 0; i < NREG; i++) begin
            logic hit;
            hit = we && a == 12'h010 + 12'(i);
            clr = ACLRM[i] ? dn[8*i +: 8] : 8'h00;
            nsh[i] = hit ? d : (m_sh[i] & ~clr);
            if (LIVEM[i] && hit) nac[i] = d;
            else if (upd)        nac[i] = m_sh[i] & ~clr;
            else                 nac[i] = m_ac[i] & ~clr;
        end
        for (int i = 0; i < NREG; i++) begin
            m_sh[i] = nsh[i];
            m_ac[i] = nac[i];
        end
    endtask

    task automatic cyc(input string tag, input logic we, input logic [11:0] a,
                       input logic [7:0] d, input logic [63:0] dn);
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; done_i = dn;
        #1;
        chk({tag, " read"}, 64'(rd_data), 64'(model_read(a)));
        model_step(we, a, d, dn);
        @(posedge clk);
        #1;
        chk({tag, " active"}, active_o, model_bus());
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [7:0] exp);
        @(negedge clk);
        wr_en = 1'b0; addr = a; done_i = '0;
        #1;
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NREG; i++) begin
            m_sh[i] = RSTV[8*i +: 8];
            m_ac[i] = RSTV[8*i +: 8];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 active defaults", active_o, RSTV);
        for (int i = 0; i < NREG; i++) rd("R1 shadow default", 12'h010 + 12'(i), RSTV[8*i +: 8]);
        rd("R1 commit reads zero", 12'h005, 8'h00);

        // R2 staging write, active held
        cyc("R2", 1'b1, 12'h010, 8'hA5, '0);
        rd("R2 readback", 12'h010, 8'hA5);
        chk("R2 active held", active_o[7:0], 64'h00);

        // R4 wrong code has no effect
        cyc("R4", 1'b1, 12'h005, 8'h02, '0);
        chk("R4 wrong code", active_o, RSTV);
        rd("R4 commit reads zero", 12'h005, 8'h00);

        // R3 commit
        cyc("R3", 1'b1, 12'h005, 8'h01, '0);
        chk("R3 lane0 committed", 64'(active_o[7:0]), 64'hA5);

        // R5 immediate register
        cyc("R5", 1'b1, 12'h012, 8'h3C, '0);
        chk("R5 live lane", 64'(active_o[23:16]), 64'h3C);

        // R6 self-clearing
        cyc("R6", 1'b1, 12'h013, 8'hFF, '0);
        cyc("R6", 1'b1, 12'h005, 8'h01, '0);
        chk("R6 set", 64'(active_o[31:24]), 64'hFF);
        cyc("R6", 1'b0, 12'h000, 8'h00, 64'h0000_0000_0F00_0000);
        chk("R6 active cleared", 64'(active_o[31:24]), 64'hF0);
        rd("R6 shadow cleared", 12'h013, 8'hF0);
        cyc("R6", 1'b0, 12'h000, 8'h00, 64'hFFFF_FFFF_00FF_FFFF);
        chk("R6 other lanes ignore done", active_o, model_bus());

        // R7 write beats done
        cyc("R7", 1'b1, 12'h013, 8'h81, 64'h0000_0000_FF00_0000);
        rd("R7 write wins", 12'h013, 8'h81);

        // R10 commit with done
        cyc("R10", 1'b1, 12'h005, 8'h01, 64'h0000_0000_0100_0000);
        chk("R10 committed with clear", 64'(active_o[31:24]), 64'h80);

        // R8 unmapped
        cyc("R8", 1'b1, 12'hE3C, 8'h55, '0);
        rd("R8 unmapped read", 12'hE3C, 8'h00);
        rd("R8 below window", 12'h00F, 8'h00);
        chk("R8 nothing changed", active_o, model_bus());

        // R9 multi-byte layout
        cyc("R9", 1'b1, 12'h010, 8'h12, '0);
        cyc("R9", 1'b1, 12'h011, 8'h34, '0);
        cyc("R9", 1'b1, 12'h005, 8'h01, '0);
        chk("R9 lsb at low address", 64'(active_o[15:0]), 64'h3412);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [11:0] a;
            logic [7:0]  d;
            logic [63:0] dn;
            logic        we;
            sel = int'($urandom % 10);
            d   = 8'($urandom);
            we  = 1'b1;
            if (sel < 6)      a = 12'h010 + 12'($urandom % 8);
            else if (sel < 8) begin a = 12'h005; if ($urandom % 2 == 0) d = 8'h01; end
            else if (sel < 9) a = 12'h100 + 12'($urandom % 256);
            else begin a = 12'($urandom % 32); we = 1'b0; end
            dn = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'h0;
            cyc("R3 R5 R6 random", we, a, d, dn);
        end

        @(negedge clk);
        wr_en = 1'b0; done_i = '0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule